// File: doc/BRIEF.md
# Boot-time Serial EEPROM Configuration Loader

After reset this block fetches a small configuration image from an external two-wire serial EEPROM and presents it as register outputs. It has its own bit-level two-wire master. The master drives the clock line and can pull the data line low. It performs random reads: a start, the device address with the write bit, the word address, a repeated start, the device address with the read bit, then a run of sequential reads. The last byte of the run is answered with a NACK, and the transfer ends with a stop.

The loader first reads only the two-byte signature at the bottom of the memory. If the signature is 0x067B, a second transfer fetches the nine bytes that follow. These give the vendor identifier, the product identifier, the release number in BCD and a 24-bit device configuration word, and they are published. If the signature is wrong, if the device never acknowledges, or if any later acknowledge is missing, the outputs keep their built-in defaults. In every case a done flag rises once, when the outcome is final. A surrounding device controller waits on that flag before it uses the identity fields.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: While `cfg_done` is low, including during and right after reset, the outputs hold the defaults: vendor 0xA5C3, product 0x4B10, release 0x0300, configuration 0x248000 (bit 21 resume-style wake, bit 18 ring-indicator wake, bit 15).
- R2: Each read transfer is START, device byte 0xA0 (7-bit address 0x50 with write bit 0), word address, repeated START, device byte 0xA1, then sequential reads. The master acknowledges every byte but the last, NACKs the last one, and ends with STOP.
- R3: The image is accepted only if address 0 holds 0x7B and address 1 holds 0x06, which is the little-endian signature 0x067B.
- R4: After acceptance, addresses 2 to 10 are fetched in one more transfer, and little-endian fields are published: vendor = {a3,a2}, product = {a5,a4}, release = {a7,a6}, configuration = {a10,a9,a8}.
- R5: In a loaded configuration word, bit 15 is always 1, and bits 23, 14, 13 and 11:6 are always 0, whatever the EEPROM holds.
- R6: On a signature mismatch, no second transfer is started (exactly two START conditions appear), and all outputs stay at their R1 defaults.
- R7: A missing acknowledge on any byte the master writes ends the transfer with a STOP, and the R1 defaults are kept. An absent device is one case of this.
- R8: `cfg_done` rises exactly once after reset and stays high, and the field outputs no longer change once it is high.
- R9: Once `cfg_done` is high the bus is idle: the clock line is high and the data line is not pulled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_o | output | 1 | Two-wire clock line level |
| sda_low_o | output | 1 | 1 pulls the data line low, 0 releases it |
| sda_i | input | 1 | Sensed level of the data line |
| vendor_id | output | 16 | Vendor identifier |
| product_id | output | 16 | Product identifier |
| release_num | output | 16 | Release number, BCD |
| dev_cfg | output | 24 | Device configuration word |
| cfg_done | output | 1 | Loading finished, whether by load or by fallback |

## Verification
The assertions check on every cycle the properties that hold regardless of memory content. Before done, the outputs equal the defaults. The reserved configuration bits are fixed. Done is sticky, the fields are frozen after done, and the bus is released after done. Only the scenarios can show the dependence on content: which bytes land in which field, that a single wrong signature byte blocks the second transfer, and that a NACK on the device byte or on a later word-address byte leads to the defaults. They show this through a behavioural EEPROM model that counts START, STOP and master-NACK events.

// File: rtl/eecl_pkg.sv
package eecl_pkg;
   typedef enum logic [1:0] {OP_START, OP_STOP, OP_WRITE, OP_READ} tw_op_e;

   typedef enum logic [3:0] {
      SQ_START1, SQ_DEVW, SQ_WADDR, SQ_START2, SQ_DEVR,
      SQ_READ, SQ_STOP, SQ_CHECK, SQ_FIN
   } seq_st_e;

   localparam int SIG_BYTES = 2;
   localparam int IMG_BYTES = 11;
endpackage

// File: rtl/tw_bit_engine.sv
module tw_bit_engine
   import eecl_pkg::*;
#(
   parameter int CLK_DIV = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       op_valid,
   input  tw_op_e     op,
   input  logic [7:0] wr_byte,
   input  logic       rd_ack,
   input  logic       sda_i,
   output logic       op_done,
   output logic       ack_seen,
   output logic [7:0] rd_byte,
   output logic       scl_o,
   output logic       sda_low_o
);
   localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

   logic             busy_q;
   tw_op_e           op_q;
   logic [DIV_W-1:0] div_q;
   logic [1:0]       ph_q;
   logic [3:0]       bit_q;
   logic [7:0]       tx_q;
   logic             ackout_q;
   logic             tick, scl_n, rel_n, last_bit;

   assign tick     = (div_q == DIV_LAST);
   assign last_bit = (op_q == OP_START || op_q == OP_STOP) ? 1'b1 : (bit_q == 4'd8);

   // quarter-bit waveform table: clock level and data release per phase
   always_comb begin
      scl_n = 1'b1;
      rel_n = 1'b1;
      case (op_q)
         OP_START: begin
            scl_n = (ph_q == 2'd1) || (ph_q == 2'd2);
            rel_n = (ph_q < 2'd2);
         end
         OP_STOP: begin
            scl_n = (ph_q != 2'd0);
            rel_n = (ph_q >= 2'd2);
         end
         OP_WRITE: begin
            scl_n = (ph_q == 2'd1) || (ph_q == 2'd2);
            rel_n = (bit_q == 4'd8) ? 1'b1 : tx_q[7];
         end
         default: begin
            scl_n = (ph_q == 2'd1) || (ph_q == 2'd2);
            rel_n = (bit_q == 4'd8) ? !ackout_q : 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         op_q      <= OP_START;
         div_q     <= '0;
         ph_q      <= '0;
         bit_q     <= '0;
         tx_q      <= '0;
         ackout_q  <= 1'b0;
         op_done   <= 1'b0;
         ack_seen  <= 1'b0;
         rd_byte   <= '0;
         scl_o     <= 1'b1;
         sda_low_o <= 1'b0;
      end else begin
         op_done <= 1'b0;
         if (!busy_q) begin
            div_q <= '0;
            if (op_valid) begin
               busy_q   <= 1'b1;
               op_q     <= op;
               ph_q     <= '0;
               bit_q    <= '0;
               tx_q     <= wr_byte;
               ackout_q <= rd_ack;
            end
         end else begin
            scl_o     <= scl_n;
            sda_low_o <= !rel_n;
            if (!tick) begin
               div_q <= div_q + 1'b1;
            end else begin
               div_q <= '0;
               if (ph_q == 2'd2) begin
                  if (bit_q == 4'd8 && op_q == OP_WRITE) ack_seen <= !sda_i;
                  if (bit_q != 4'd8 && op_q == OP_READ) rd_byte <= {rd_byte[6:0], sda_i};
               end
               if (ph_q == 2'd3) begin
                  ph_q <= '0;
                  if (op_q == OP_WRITE) tx_q <= {tx_q[6:0], 1'b1};
                  if (last_bit) begin
                     busy_q  <= 1'b0;
                     op_done <= 1'b1;
                  end else begin
                     bit_q <= bit_q + 1'b1;
                  end
               end else begin
                  ph_q <= ph_q + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/cfg_read_seq.sv
module cfg_read_seq
   import eecl_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR = 7'h50,
   parameter logic [15:0] SIG_WORD = 16'h067B
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   op_done,
   input  logic                   ack_seen,
   input  logic [7:0]             rd_byte,
   output logic                   op_valid,
   output tw_op_e                 op,
   output logic [7:0]             wr_byte,
   output logic                   rd_ack,
   output logic [IMG_BYTES*8-1:0] image,
   output logic                   finish,
   output logic                   accept
);
   localparam logic [3:0] LAST_SIG = 4'(SIG_BYTES - 1);
   localparam logic [3:0] LAST_IMG = 4'(IMG_BYTES - 1);

   seq_st_e    st_q;
   logic       wait_q, second_q, abort_q;
   logic [3:0] idx_q;
   logic [7:0] base;
   logic [3:0] last_idx;

   assign base     = second_q ? 8'(SIG_BYTES) : 8'd0;
   assign last_idx = second_q ? LAST_IMG : LAST_SIG;
   assign rd_ack   = (idx_q != last_idx);

   always_comb begin
      op_valid = 1'b0;
      op       = OP_START;
      wr_byte  = 8'hFF;
      case (st_q)
         SQ_START1, SQ_START2: op_valid = !wait_q;
         SQ_DEVW: begin op_valid = !wait_q; op = OP_WRITE; wr_byte = {DEV_ADDR, 1'b0}; end
         SQ_WADDR: begin op_valid = !wait_q; op = OP_WRITE; wr_byte = base; end
         SQ_DEVR: begin op_valid = !wait_q; op = OP_WRITE; wr_byte = {DEV_ADDR, 1'b1}; end
         SQ_READ: begin op_valid = !wait_q; op = OP_READ; end
         SQ_STOP: begin op_valid = !wait_q; op = OP_STOP; end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SQ_START1;
         wait_q   <= 1'b0;
         second_q <= 1'b0;
         abort_q  <= 1'b0;
         idx_q    <= '0;
         image    <= '0;
         finish   <= 1'b0;
         accept   <= 1'b0;
      end else begin
         finish <= 1'b0;
         accept <= 1'b0;
         if (op_valid) wait_q <= 1'b1;
         if (st_q == SQ_CHECK) begin
            if (image[SIG_BYTES*8-1:0] == SIG_WORD) begin
               second_q <= 1'b1;
               st_q     <= SQ_START1;
            end else begin
               st_q   <= SQ_FIN;
               finish <= 1'b1;
            end
         end else if (op_done) begin
            wait_q <= 1'b0;
            case (st_q)
               SQ_START1: st_q <= SQ_DEVW;
               SQ_START2: st_q <= SQ_DEVR;
               SQ_DEVW, SQ_WADDR, SQ_DEVR: begin
                  if (!ack_seen) begin
                     abort_q <= 1'b1;
                     st_q    <= SQ_STOP;
                  end else if (st_q == SQ_DEVW) begin
                     st_q <= SQ_WADDR;
                  end else if (st_q == SQ_WADDR) begin
                     st_q <= SQ_START2;
                  end else begin
                     idx_q <= base[3:0];
                     st_q  <= SQ_READ;
                  end
               end
               SQ_READ: begin
                  image[idx_q*8 +: 8] <= rd_byte;
                  if (idx_q == last_idx) st_q <= SQ_STOP;
                  else idx_q <= idx_q + 1'b1;
               end
               SQ_STOP: begin
                  if (abort_q || second_q) begin
                     st_q   <= SQ_FIN;
                     finish <= 1'b1;
                     accept <= !abort_q;
                  end else begin
                     st_q <= SQ_CHECK;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
   import eecl_pkg::*;
#(
   parameter int          CLK_DIV      = 8,
   parameter logic [6:0]  DEV_ADDR     = 7'h50,
   parameter logic [15:0] SIG_WORD     = 16'h067B,
   parameter logic [15:0] DEF_VID      = 16'hA5C3,
   parameter logic [15:0] DEF_PID      = 16'h4B10,
   parameter logic [15:0] DEF_REL      = 16'h0300,
   parameter logic [23:0] DEF_CFG      = 24'h248000,
   parameter logic [23:0] CFG_SET_MASK = 24'h008000,
   parameter logic [23:0] CFG_CLR_MASK = 24'h806FC0
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic        scl_o,
   output logic        sda_low_o,
   input  logic        sda_i,
   output logic [15:0] vendor_id,
   output logic [15:0] product_id,
   output logic [15:0] release_num,
   output logic [23:0] dev_cfg,
   output logic        cfg_done
);
   if (CLK_DIV < 1) begin : g_bad_div
      $error("CLK_DIV must be at least 1");
   end
   if ((CFG_SET_MASK & CFG_CLR_MASK) != 24'h0) begin : g_bad_mask
      $error("configuration set and clear masks overlap");
   end
   if (((DEF_CFG & CFG_CLR_MASK) != 24'h0) || ((DEF_CFG & CFG_SET_MASK) != CFG_SET_MASK)) begin : g_bad_def
      $error("default configuration violates the fixed bits");
   end

   logic                   op_valid, op_done, ack_seen, rd_ack, finish, accept;
   tw_op_e                 op;
   logic [7:0]             wr_byte, rd_byte;
   logic [IMG_BYTES*8-1:0] image;
   logic [23:0]            cfg_raw, cfg_fix;

   tw_bit_engine #(.CLK_DIV(CLK_DIV)) u_engine (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .wr_byte(wr_byte),
      .rd_ack(rd_ack), .sda_i(sda_i), .op_done(op_done), .ack_seen(ack_seen),
      .rd_byte(rd_byte), .scl_o(scl_o), .sda_low_o(sda_low_o)
   );

   cfg_read_seq #(.DEV_ADDR(DEV_ADDR), .SIG_WORD(SIG_WORD)) u_seq (
      .clk(clk), .rst_n(rst_n), .op_done(op_done), .ack_seen(ack_seen),
      .rd_byte(rd_byte), .op_valid(op_valid), .op(op), .wr_byte(wr_byte),
      .rd_ack(rd_ack), .image(image), .finish(finish), .accept(accept)
   );

   assign cfg_raw = image[87:64];

   for (genvar i = 0; i < 24; i++) begin : g_cfg_bit
      if (CFG_SET_MASK[i]) begin : g_one
         assign cfg_fix[i] = 1'b1;
      end else if (CFG_CLR_MASK[i]) begin : g_zero
         assign cfg_fix[i] = 1'b0;
      end else begin : g_pass
         assign cfg_fix[i] = cfg_raw[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vendor_id   <= DEF_VID;
         product_id  <= DEF_PID;
         release_num <= DEF_REL;
         dev_cfg     <= DEF_CFG;
         cfg_done    <= 1'b0;
      end else if (finish) begin
         cfg_done <= 1'b1;
         if (accept) begin
            vendor_id   <= image[31:16];
            product_id  <= image[47:32];
            release_num <= image[63:48];
            dev_cfg     <= cfg_fix;
         end
      end
   end
endmodule

// File: rtl/eecl_checker.sv
module eecl_checker #(
   parameter logic [15:0] DEF_VID      = 16'hA5C3,
   parameter logic [15:0] DEF_PID      = 16'h4B10,
   parameter logic [15:0] DEF_REL      = 16'h0300,
   parameter logic [23:0] DEF_CFG      = 24'h248000,
   parameter logic [23:0] CFG_SET_MASK = 24'h008000,
   parameter logic [23:0] CFG_CLR_MASK = 24'h806FC0
) (
   input logic        clk,
   input logic        rst_n,
   input logic        scl_o,
   input logic        sda_low_o,
   input logic [15:0] vendor_id,
   input logic [15:0] product_id,
   input logic [15:0] release_num,
   input logic [23:0] dev_cfg,
   input logic        cfg_done
);
   assert_defaults_until_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_done |-> (vendor_id == DEF_VID && product_id == DEF_PID &&
                     release_num == DEF_REL && dev_cfg == DEF_CFG));

   assert_fixed_cfg_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((dev_cfg & CFG_CLR_MASK) == 24'h0) && ((dev_cfg & CFG_SET_MASK) == CFG_SET_MASK));

   assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |=> cfg_done);

   assert_fields_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |=> ($stable(vendor_id) && $stable(product_id) &&
                    $stable(release_num) && $stable(dev_cfg)));

   assert_bus_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |-> (scl_o && !sda_low_o));
endmodule

bind eeprom_cfg_loader eecl_checker #(
   .DEF_VID(DEF_VID), .DEF_PID(DEF_PID), .DEF_REL(DEF_REL), .DEF_CFG(DEF_CFG),
   .CFG_SET_MASK(CFG_SET_MASK), .CFG_CLR_MASK(CFG_CLR_MASK)
) u_eecl_checker (
   .clk(clk), .rst_n(rst_n), .scl_o(scl_o), .sda_low_o(sda_low_o),
   .vendor_id(vendor_id), .product_id(product_id), .release_num(release_num),
   .dev_cfg(dev_cfg), .cfg_done(cfg_done)
);

// File: tb/eeprom_cfg_loader_test.sv
module eeprom_cfg_loader_test;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 4;
   localparam logic [6:0]  DEV     = 7'h50;
   localparam logic [15:0] D_VID   = 16'hA5C3;
   localparam logic [15:0] D_PID   = 16'h4B10;
   localparam logic [15:0] D_REL   = 16'h0300;
   localparam logic [23:0] D_CFG   = 24'h248000;
   localparam logic [23:0] M_SET   = 24'h008000;
   localparam logic [23:0] M_CLR   = 24'h806FC0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic        scl_o, sda_low_o, sda_i, cfg_done;
   logic [15:0] vendor_id, product_id, release_num;
   logic [23:0] dev_cfg;
   logic        slv_low = 1'b0;
   assign sda_i = !(sda_low_o || slv_low);

   eeprom_cfg_loader #(.CLK_DIV(DIV)) uut (
      .clk(clk), .rst_n(rst_n), .scl_o(scl_o), .sda_low_o(sda_low_o), .sda_i(sda_i),
      .vendor_id(vendor_id), .product_id(product_id), .release_num(release_num),
      .dev_cfg(dev_cfg), .cfg_done(cfg_done)
   );

   int tests = 0;
   int fails = 0;

   // ---------------- behavioural EEPROM ----------------
   logic [7:0] mem [0:15];
   bit   present = 1'b1;
   bit   nack_w  = 1'b0;
   int   st, bitn, ptr, starts, stops, mnacks;
   logic [7:0] shr, txb;
   bit   ackf, rw;
   logic pscl, psda;

   always @(negedge clk) begin
      logic b;
      b = sda_i;
      if (!rst_n) begin
         st = 0; bitn = 0; ptr = 0; starts = 0; stops = 0; mnacks = 0;
         slv_low = 1'b0; pscl = 1'b1; psda = 1'b1; ackf = 1'b0; rw = 1'b0;
         shr = '0; txb = '0;
      end else begin
         if (pscl && scl_o && psda && !b) begin
            starts++; st = 1; bitn = 0; ackf = 1'b0;
         end else if (pscl && scl_o && !psda && b) begin
            stops++; st = 0;
         end else if (!pscl && scl_o && st != 0) begin
            if (st == 4) begin
               if (bitn < 8) bitn++;
               else begin
                  bitn = 0;
                  if (b) begin mnacks++; st = 0; end
                  else begin ptr = (ptr + 1) % 16; txb = mem[ptr]; end
               end
            end else if (bitn < 8) begin
               shr = {shr[6:0], b};
               bitn++;
               if (bitn == 8) begin
                  if (st == 1) begin ackf = present && (shr[7:1] == DEV); rw = shr[0]; end
                  else if (st == 2) begin ptr = shr % 16; ackf = !(nack_w && shr != 8'd0); end
                  else ackf = 1'b1;
               end
            end else begin
               bitn = 0;
               if (!ackf) st = 0;
               else if (st == 1) begin
                  if (rw) begin st = 4; txb = mem[ptr]; end else st = 2;
               end else if (st == 2) st = 3;
            end
         end else if (pscl && !scl_o) begin
            if (st == 0) slv_low = 1'b0;
            else if (st == 4) slv_low = (bitn < 8) ? !txb[7-bitn] : 1'b0;
            else slv_low = (bitn == 8) && ackf;
         end
         pscl = scl_o;
         psda = b;
      end
   end

   // ---------------- per-cycle reference comparison ----------------
   bit          active = 1'b0;
   int          mism = 0;
   logic [15:0] e_vid, e_pid, e_rel;
   logic [23:0] e_cfg;

   always @(negedge clk) begin
      if (rst_n && active) begin
         if (!cfg_done) begin
            if (vendor_id != D_VID || product_id != D_PID || release_num != D_REL || dev_cfg != D_CFG)
               mism++;
         end else if (vendor_id != e_vid || product_id != e_pid || release_num != e_rel || dev_cfg != e_cfg) begin
            mism++;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic load_mem(input logic [7:0] b0, b1, b2, b3, b4, b5, b6, b7, b8, b9, b10);
      mem[0] = b0; mem[1] = b1; mem[2] = b2; mem[3] = b3; mem[4] = b4; mem[5] = b5;
      mem[6] = b6; mem[7] = b7; mem[8] = b8; mem[9] = b9; mem[10] = b10;
      for (int k = 11; k < 16; k++) mem[k] = 8'hEE;
   endtask

   task automatic run(input string req, input bit pres, input bit nw, input bit exp_ok,
                      input int exp_starts, input int exp_stops, input int exp_nacks);
      int waited;
      present = pres;
      nack_w  = nw;
      active  = 1'b0;
      rst_n   = 1'b0;
      if (exp_ok) begin
         e_vid = {mem[3], mem[2]};
         e_pid = {mem[5], mem[4]};
         e_rel = {mem[7], mem[6]};
         e_cfg = ({mem[10], mem[9], mem[8]} & ~M_CLR) | M_SET;
      end else begin
         e_vid = D_VID; e_pid = D_PID; e_rel = D_REL; e_cfg = D_CFG;
      end
      mism = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!cfg_done && vendor_id == D_VID && dev_cfg == D_CFG, "R1", "reset state",
          {cfg_done, vendor_id, dev_cfg}, {1'b0, D_VID, D_CFG});
      rst_n  = 1'b1;
      active = 1'b1;
      waited = 0;
      while (!cfg_done && waited < 20000) begin
         @(negedge clk);
         waited++;
      end
      chk(cfg_done, "R8", {req, " done rises"}, cfg_done, 1);
      repeat (30) @(negedge clk);
      chk(cfg_done, "R8", {req, " done stays high"}, cfg_done, 1);
      chk(mism == 0, "R1", {req, " per-cycle reference mismatches"}, mism, 0);
      chk(vendor_id == e_vid, "R4", {req, " vendor"}, vendor_id, e_vid);
      chk(product_id == e_pid, "R4", {req, " product"}, product_id, e_pid);
      chk(release_num == e_rel, "R4", {req, " release"}, release_num, e_rel);
      chk(dev_cfg == e_cfg, "R5", {req, " configuration"}, dev_cfg, e_cfg);
      chk(starts == exp_starts, "R6", {req, " START count"}, starts, exp_starts);
      chk(stops == exp_stops, "R7", {req, " STOP count"}, stops, exp_stops);
      chk(mnacks == exp_nacks, "R2", {req, " final-byte NACK count"}, mnacks, exp_nacks);
      chk(scl_o && !sda_low_o, "R9", {req, " bus released"}, {scl_o, sda_low_o}, 2'b10);
      active = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL R8 watchdog expired: actual 0x0 expected 0x1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      // R3 R4 R5: valid image, all-ones configuration gets fixed bits applied
      load_mem(8'h7B, 8'h06, 8'h34, 8'h12, 8'h78, 8'h56, 8'h00, 8'h01, 8'hFF, 8'hFF, 8'hFF);
      run("R3 valid", 1'b1, 1'b0, 1'b1, 4, 2, 2);
      chk(dev_cfg == 24'h7F903F, "R5", "all-ones masked", dev_cfg, 24'h7F903F);
      // R4 R5: valid image, all-zero configuration forces bit 15
      load_mem(8'h7B, 8'h06, 8'hCD, 8'hAB, 8'h01, 8'hEF, 8'h99, 8'h02, 8'h00, 8'h00, 8'h00);
      run("R4 zero-cfg", 1'b1, 1'b0, 1'b1, 4, 2, 2);
      // R6: byte-swapped signature
      load_mem(8'h06, 8'h7B, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88, 8'h99);
      run("R6 swapped sig", 1'b1, 1'b0, 1'b0, 2, 1, 1);
      // R6: one high byte off by one
      load_mem(8'h7B, 8'h07, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88, 8'h99);
      run("R6 near sig", 1'b1, 1'b0, 1'b0, 2, 1, 1);
      // R7: no device answers
      load_mem(8'h7B, 8'h06, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88, 8'h99);
      run("R7 absent", 1'b0, 1'b0, 1'b0, 1, 1, 0);
      // R7: device NACKs the second word address
      run("R7 late nack", 1'b1, 1'b1, 1'b0, 3, 2, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule